// File: doc/BRIEF.md
# I2C Memory Slave with Write Protection

This block is the two-wire serial front end of a small on-chip byte memory. It watches an open-drain clock line and data line from an external controller. Both lines are brought into the fast system clock domain through synchronizers. The block recognises bus start and stop events and keeps a bus-busy flag. After each start it decodes a 7-bit device identifier. It then either loads a byte pointer and stores incoming data, or returns stored data. The pointer advances by one after every byte moved.

Each received byte is answered in the ninth clock slot by pulling the data line low (accept) or leaving it released (refuse). A static protection setting refuses data bytes aimed at the low part of the memory. A refused byte is never stored, and the slave then stays silent until the controller issues a new start or a stop. The data line is only ever pulled low through an output-enable signal; the block never drives it high.

Top module: `i2c_wp_mem_slave`

## Requirements
- R1: After reset `bus_busy` and `sda_oe` are 0. `bus_busy` goes to 1 after a start event (data falling while clock is high) and returns to 0 only after a stop event (data rising while clock is high).
- R2: A repeated start (a start while `bus_busy` is 1) leaves `bus_busy` at 1, and the next byte is decoded as a device identifier.
- R3: The first byte after a start carries the identifier in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). A match with `DEV_ID` (default 7'h50, so 8'hA0 / 8'hA1) is acknowledged. A mismatch is refused, and the slave leaves the data line released until the next start.
- R4: In a write, the byte after the identifier loads the pointer from its low `ADDR_W` bits and is acknowledged. Every later byte is stored at the pointer and acknowledged, and the pointer then advances by one, wrapping from 2^`ADDR_W`-1 to 0.
- R5: In a read, the slave sends the byte at the pointer MSB first, advances the pointer after each byte, and keeps sending while the controller acknowledges. A read that follows a write with no data byte begins at the pointer loaded by that write.
- R6: When the controller refuses (data high in the ninth slot) a byte during a read, the slave releases the data line and sends nothing more until a start or stop. Further clocks read 8'hFF.
- R7: With `wp_en`=1, a data byte whose target address is below `wp_bound` is neither stored nor acknowledged, and the pointer does not advance. Every further byte up to the next start or stop is ignored and left unacknowledged. An address equal to `wp_bound` is writable, and `wp_bound`=0 protects nothing.
- R8: `sda_oe` is 1 only in an acknowledge slot or while sending a 0 data bit. It changes only just after a clock falling edge, a start or a stop, and it is 0 after a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level as seen at the pad |
| sda_i | input | 1 | Serial data line level as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| bus_busy | output | 1 | 1 between a start and the following stop |
| wp_en | input | 1 | Enables the protected address range |
| wp_bound | input | ADDR_W | Addresses strictly below this value are protected |

## Verification
A wrong protocol state almost always shows in the ninth clock slot of the next byte. An accept appears where a refuse was expected, or the reverse, so the error is visible within nine serial clocks. A stale or misrouted pointer shows on the next read-back, because the returned byte differs from the one written at that address. A slave that keeps driving after a refusal shows as a data byte other than 8'hFF on the following clocks. A corrupted bus-busy flag is visible on its own pin a few system cycles after the start or stop that should have moved it.

// File: rtl/i2cmem_pkg.sv
`timescale 1ns/1ps
package i2cmem_pkg;

    localparam int BYTE_BITS = 8;
    localparam int LINE_SDA  = 0;
    localparam int LINE_SCL  = 1;
    localparam int NUM_LINES = 2;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start
        ST_RX,     // shifting in a byte
        ST_RACK,   // driving our acknowledge
        ST_TX,     // shifting out a byte
        ST_TACK,   // reading controller acknowledge
        ST_HOLD    // ignoring bus until start or stop
    } slv_state_e;

    typedef enum logic [1:0] {
        PH_ID,
        PH_PTR,
        PH_DATA
    } byte_phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

    function automatic logic id_match(input logic [6:0] id_bits, input logic [6:0] own_id);
        return id_bits == own_id;
    endfunction

    function automatic logic in_wp(input logic en, input logic [15:0] addr, input logic [15:0] bound);
        return en && (addr < bound);
    endfunction

endpackage

// File: rtl/i2cmem_busmon.sv
`timescale 1ns/1ps
module i2cmem_busmon
    import i2cmem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt,
    output logic     bus_busy
);

    logic [NUM_LINES-1:0] line_in;
    logic [NUM_LINES-1:0] line_now;
    logic [NUM_LINES-1:0] line_prev;

    assign line_in[LINE_SCL] = scl_i;
    assign line_in[LINE_SDA] = sda_i;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [SYNC_STAGES-1:0] pipe;
        logic                   prev;
        always_ff @(posedge clk) begin
            if (rst) begin
                pipe <= '1;
                prev <= 1'b1;
            end else begin
                pipe <= {pipe[SYNC_STAGES-2:0], line_in[g]};
                prev <= pipe[SYNC_STAGES-1];
            end
        end
        assign line_now[g]  = pipe[SYNC_STAGES-1];
        assign line_prev[g] = prev;
    end

    logic scl_held_high;
    assign scl_held_high = line_now[LINE_SCL] & line_prev[LINE_SCL];

    always_comb begin
        evt.start = scl_held_high &  line_prev[LINE_SDA] & ~line_now[LINE_SDA];
        evt.stop  = scl_held_high & ~line_prev[LINE_SDA] &  line_now[LINE_SDA];
        evt.rise  =  line_now[LINE_SCL] & ~line_prev[LINE_SCL];
        evt.fall  = ~line_now[LINE_SCL] &  line_prev[LINE_SCL];
        evt.sda   =  line_now[LINE_SDA];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_busy <= 1'b0;
        end else if (evt.stop) begin
            bus_busy <= 1'b0;
        end else if (evt.start) begin
            bus_busy <= 1'b1;
        end
    end

endmodule

// File: rtl/i2cmem_regfile.sv
`timescale 1ns/1ps
module i2cmem_regfile #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
            rdata <= '0;
        end else begin
            if (we) begin
                cells[waddr] <= wdata;
            end
            rdata <= cells[raddr];
        end
    end

endmodule

// File: rtl/i2cmem_engine.sv
`timescale 1ns/1ps
module i2cmem_engine
    import i2cmem_pkg::*;
#(
    parameter int         ADDR_W = 6,
    parameter logic [6:0] DEV_ID = 7'h50
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic              wp_en,
    input  logic [ADDR_W-1:0] wp_bound,
    input  logic [7:0]        rdata,
    output logic              sda_oe,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    output logic [ADDR_W-1:0] ptr_o
);

    localparam int          CNT_W    = 4;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_BITS);

    slv_state_e       state;
    byte_phase_e      phase;
    logic [CNT_W-1:0] bitcnt;
    logic [6:0]       shreg;
    logic             rd_xfer;
    logic             ack_ok;
    logic             m_ack;
    logic [ADDR_W-1:0] ptr;

    logic [7:0] rx_byte;
    logic       byte_done;
    logic       wp_hit;
    logic       ack_take;
    logic       wr_take;

    assign rx_byte   = {shreg, evt.sda};
    assign byte_done = (state == ST_RX) && evt.rise && (bitcnt == LAST_BIT);
    assign wp_hit    = in_wp(wp_en, 16'(ptr), 16'(wp_bound));

    always_comb begin
        ack_take = 1'b0;
        wr_take  = 1'b0;
        case (phase)
            PH_ID:   ack_take = id_match(rx_byte[7:1], DEV_ID);
            PH_PTR:  ack_take = 1'b1;
            default: begin
                ack_take = !wp_hit;
                wr_take  = !wp_hit;
            end
        endcase
    end

    assign mem_we    = byte_done && wr_take;
    assign mem_wdata = rx_byte;
    assign ptr_o     = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            phase   <= PH_ID;
            bitcnt  <= '0;
            shreg   <= '0;
            rd_xfer <= 1'b0;
            ack_ok  <= 1'b0;
            m_ack   <= 1'b0;
            sda_oe  <= 1'b0;
            ptr     <= '0;
        end else if (evt.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else if (evt.start) begin
            state  <= ST_RX;
            phase  <= PH_ID;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (evt.rise && bitcnt < ACK_BIT) begin
                        shreg  <= rx_byte[6:0];
                        bitcnt <= bitcnt + CNT_W'(1);
                        if (bitcnt == LAST_BIT) begin
                            ack_ok <= ack_take;
                            if (phase == PH_ID) begin
                                rd_xfer <= rx_byte[0];
                            end
                            if (phase == PH_PTR) begin
                                ptr <= rx_byte[ADDR_W-1:0];
                            end
                            if (mem_we) begin
                                ptr <= ptr + ADDR_W'(1);
                            end
                        end
                    end else if (evt.fall && bitcnt == ACK_BIT) begin
                        if (ack_ok) begin
                            sda_oe <= 1'b1;
                            state  <= ST_RACK;
                        end else begin
                            state <= (phase == PH_ID) ? ST_IDLE : ST_HOLD;
                        end
                    end
                end
                ST_RACK: begin
                    if (evt.fall) begin
                        bitcnt <= '0;
                        if (phase == PH_ID && rd_xfer) begin
                            shreg  <= rdata[6:0];
                            sda_oe <= ~rdata[7];
                            phase  <= PH_DATA;
                            state  <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            phase  <= (phase == PH_ID) ? PH_PTR : PH_DATA;
                            state  <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (evt.fall) begin
                        if (bitcnt == LAST_BIT) begin
                            sda_oe <= 1'b0;
                            ptr    <= ptr + ADDR_W'(1);
                            state  <= ST_TACK;
                        end else begin
                            sda_oe <= ~shreg[6];
                            shreg  <= {shreg[5:0], 1'b0};
                            bitcnt <= bitcnt + CNT_W'(1);
                        end
                    end
                end
                ST_TACK: begin
                    if (evt.rise) begin
                        m_ack <= ~evt.sda;
                    end else if (evt.fall) begin
                        if (m_ack) begin
                            shreg  <= rdata[6:0];
                            sda_oe <= ~rdata[7];
                            bitcnt <= '0;
                            state  <= ST_TX;
                        end else begin
                            state <= ST_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/i2c_wp_mem_slave.sv
`timescale 1ns/1ps
module i2c_wp_mem_slave
    import i2cmem_pkg::*;
#(
    parameter int         ADDR_W      = 6,
    parameter logic [6:0] DEV_ID      = 7'h50,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              bus_busy,
    input  logic              wp_en,
    input  logic [ADDR_W-1:0] wp_bound
);

    bus_evt_t          evt;
    logic              start_det;
    logic              stop_det;
    logic              scl_fall;
    logic              mem_we;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] mem_waddr;

    assign start_det = evt.start;
    assign stop_det  = evt.stop;
    assign scl_fall  = evt.fall;
    assign mem_waddr = ptr_q;

    i2cmem_busmon #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_busmon (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .evt      (evt),
        .bus_busy (bus_busy)
    );

    i2cmem_engine #(
        .ADDR_W (ADDR_W),
        .DEV_ID (DEV_ID)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .wp_en     (wp_en),
        .wp_bound  (wp_bound),
        .rdata     (mem_rdata),
        .sda_oe    (sda_oe),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .ptr_o     (ptr_q)
    );

    i2cmem_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (8)
    ) u_regfile (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (ptr_q),
        .rdata (mem_rdata)
    );

endmodule

// File: rtl/i2cmem_chk.sv
`timescale 1ns/1ps
module i2cmem_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_busy,
    input logic              sda_oe,
    input logic              start_det,
    input logic              stop_det,
    input logic              scl_fall,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_waddr,
    input logic [ADDR_W-1:0] ptr_q,
    input logic              wp_en,
    input logic [ADDR_W-1:0] wp_bound
);

    assert_busy_set_R1: assert property (@(posedge clk) disable iff (rst)
        start_det |=> bus_busy);

    assert_busy_clear_R1: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !bus_busy);

    assert_busy_fall_only_on_stop_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_busy) |-> $past(stop_det));

    assert_busy_rise_only_on_start_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_busy) |-> $past(start_det));

    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (ptr_q == ADDR_W'($past(mem_waddr) + 1'b1)));

    assert_no_protected_store_R7: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (!wp_en || (mem_waddr >= wp_bound)));

    assert_release_after_stop_R8: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe);

    assert_drive_changes_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

endmodule

bind i2c_wp_mem_slave i2cmem_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_busy  (bus_busy),
    .sda_oe    (sda_oe),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_fall  (scl_fall),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .ptr_q     (ptr_q),
    .wp_en     (wp_en),
    .wp_bound  (wp_bound)
);

// File: tb/i2c_wp_mem_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_wp_mem_slave_tb_top;

    localparam int ADDR_W = 6;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int Q      = 10;
    localparam int NVEC   = 6;

    typedef struct packed {
        logic       wp;
        logic [5:0] bound;
        logic [5:0] addr;
        logic [7:0] data;
        logic       ack;
    } vec_t;

    // wp, bound, addr, data, expected acknowledge
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 6'd0,  6'd5,  8'hA5, 1'b1},
        '{1'b1, 6'd16, 6'd5,  8'h3C, 1'b0},
        '{1'b1, 6'd16, 6'd16, 8'h77, 1'b1},
        '{1'b1, 6'd16, 6'd15, 8'h11, 1'b0},
        '{1'b0, 6'd16, 6'd15, 8'h22, 1'b1},
        '{1'b1, 6'd0,  6'd0,  8'h99, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp_en = 1'b0;
    logic [ADDR_W-1:0] wp_bound = '0;
    logic sda_oe;
    logic bus_busy;
    logic sda_line;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] model [DEPTH];

    assign sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    i2c_wp_mem_slave #(
        .ADDR_W      (ADDR_W),
        .DEV_ID      (7'h50),
        .SYNC_STAGES (2)
    ) dut_i (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .bus_busy (bus_busy),
        .wp_en    (wp_en),
        .wp_bound (wp_bound)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wait_q();
        scl_m = 1'b1; wait_q(); wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        b = sda_line; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    // returns 1 when the slave acknowledged
    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) bit_in(d[i]);
        bit_out(~give_ack);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic a;
        logic [7:0] d;
        for (int m = 0; m < DEPTH; m++) model[m] = 8'h00;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset bus_busy", bus_busy, 0);
        chk("R8 reset sda_oe", sda_oe, 0);

        // table walk: one write then one read-back per vector
        for (int v = 0; v < NVEC; v++) begin
            wp_en    = VECS[v].wp;
            wp_bound = VECS[v].bound;
            bus_start();
            send_byte(8'hA0, a);
            send_byte({2'b00, VECS[v].addr}, a);
            send_byte(VECS[v].data, a);
            bus_stop();
            chk("R4/R7 table data ack", a, VECS[v].ack);
            if (VECS[v].ack) model[VECS[v].addr] = VECS[v].data;
            bus_start();
            send_byte(8'hA0, a);
            send_byte({2'b00, VECS[v].addr}, a);
            bus_start();
            send_byte(8'hA1, a);
            recv_byte(1'b0, d);
            bus_stop();
            chk("R5/R7 table read-back", d, model[VECS[v].addr]);
        end
        wp_en = 1'b0;
        wp_bound = '0;

        // R1 / R2: busy flag across a repeated start
        bus_start();
        chk("R1 busy after start", bus_busy, 1);
        send_byte(8'hA0, a);
        chk("R3 matching write id acked", a, 1);
        bus_start();
        chk("R2 busy kept over repeated start", bus_busy, 1);
        send_byte(8'hA1, a);
        chk("R2 id decoded after repeated start", a, 1);
        recv_byte(1'b0, d);
        bus_stop();
        wait_q();
        chk("R1 busy cleared after stop", bus_busy, 0);
        chk("R8 released after stop", sda_oe, 0);

        // R3: wrong identifier
        bus_start();
        send_byte(8'hA2, a);
        chk("R3 mismatched id refused", a, 0);
        send_byte(8'h00, a);
        chk("R3 bytes after mismatch ignored", a, 0);
        chk("R3 line released after mismatch", sda_oe, 0);
        bus_stop();

        // R4 / R5 / R6: burst write across the top, burst read
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'd62, a);
        chk("R4 pointer byte acked", a, 1);
        send_byte(8'hC1, a); chk("R4 burst byte 0 acked", a, 1);
        send_byte(8'hC2, a); chk("R4 burst byte 1 acked", a, 1);
        send_byte(8'hC3, a); chk("R4 burst byte 2 acked after wrap", a, 1);
        bus_stop();
        model[62] = 8'hC1; model[63] = 8'hC2; model[0] = 8'hC3;
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'd62, a);
        bus_start();
        send_byte(8'hA1, a);
        recv_byte(1'b1, d); chk("R5 burst read byte 0", d, model[62]);
        recv_byte(1'b1, d); chk("R5 burst read byte 1", d, model[63]);
        recv_byte(1'b0, d); chk("R4 read wraps to address 0", d, model[0]);
        recv_byte(1'b1, d); chk("R6 silent after controller refusal", d, 8'hFF);
        chk("R6 line released after refusal", sda_oe, 0);
        bus_stop();

        // R7: protected byte stalls the transaction until a repeated start
        wp_en = 1'b1;
        wp_bound = 6'd15;
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'd14, a);
        chk("R7 pointer into protected range acked", a, 1);
        send_byte(8'h55, a);
        chk("R7 protected byte refused", a, 0);
        send_byte(8'h66, a);
        chk("R7 byte after refusal ignored", a, 0);
        bus_start();
        send_byte(8'hA0, a);
        chk("R2 repeated start recovers after refusal", a, 1);
        send_byte(8'd14, a);
        bus_start();
        send_byte(8'hA1, a);
        recv_byte(1'b0, d);
        bus_stop();
        chk("R7 protected cell unchanged", d, model[14]);
        wp_en = 1'b0;
        wp_bound = '0;

        // R5: read from pointer left by a pointer-only write
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'd20, a);
        send_byte(8'h5A, a);
        bus_stop();
        model[20] = 8'h5A;
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'd20, a);
        bus_stop();
        bus_start();
        send_byte(8'hA1, a);
        chk("R3 read id acked", a, 1);
        recv_byte(1'b0, d);
        bus_stop();
        chk("R5 current-pointer read", d, model[20]);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule